// File: doc/BRIEF.md
# Spread-Spectrum Frequency Control Generator

This block is the digital control core of a spread-spectrum clock synthesizer. It reads the static selection inputs of the synthesizer: a three-bit spread width code, two-bit input and output band codes, an active-low spread enable and a stop input. From them it produces a signed frequency offset that follows a triangular sweep. The offset is meant to steer a fractional-N divider or a digitally controlled oscillator.

The block also produces a multiplication factor, given as a signed power of two, and the enables for the swept clock output and the unswept reference copy. The sweep repeats every `4 * 2**SWEEP_QUARTER_LOG2` clock cycles. The default is 1024 cycles, which is close to one thousandth of the output clock rate.

The lowest bit of the width code picks the spread style. In down spread the frequency only falls below nominal. In center spread it swings equally above and below. New settings are latched only at the start of a sweep period, where the offset is zero in every mode, so the frequency never steps.

The offset is expressed in units of 1/100000 of the nominal frequency. In these units every legal width is an integer, including 0.625 %.

Top module: `ssc_freq_ctrl`

## Requirements
- R1: With the applied width code bit 0 = 0 (down spread), let `W = 1250 << code[2:1]` (1.25 %, 2.5 %, 5 % or 10 %) and let `d` be the phase folded at the half period `H = 2Q`. The offset is `-floor(W*d/H)`. It is never positive, and it reaches exactly `-W` at mid-period.
- R2: With the applied width code bit 0 = 1 (center spread), let `A = 625 << code[2:1]` and let `s` be the signed triangle of the phase (rising from 0 to +Q, falling to -Q, returning to 0). The offset is `A*s/Q`, truncated toward zero, and stays within ±A.
- R3: While the applied setting has spread disabled (`spreadEnN` = 1), the offset is zero.
- R4: A change to `widthCode` or `spreadEnN`, or to the spread-off condition of R8, is applied only when the sweep phase is 0. Until that point the offset keeps following the previous setting.
- R5: `stop` = 1 drives both `spreadClkEn` and `refClkEn` to 0 one cycle later. `stop` = 0 drives both to 1 one cycle later.
- R6: `refClkEn` depends only on `stop` and never on `spreadEnN` or the width code; it always equals `spreadClkEn`.
- R7: For nonzero band codes, `factorLog2` equals `outRange - inRange` as a 3-bit two's-complement value, one cycle after the inputs change. Codes 1, 2 and 3 have lower band edges of 12.5, 25 and 50 MHz, so the factor is 2^(outRange-inRange).
- R8: Band code 00 on either input sets `rangeErr` = 1 and `factorLog2` = 0 one cycle later. It also forces the spread off from the next period start.
- R9: While `rst` is high at a clock edge, phase, offset, factor, error flag and both enables return to 0.
- R10: The sweep period is `4*Q` cycles, with `Q = 2**SWEEP_QUARTER_LOG2`. The offset produced from phase 0 is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| widthCode | input | 3 | Spread width code; bit 0 selects center spread |
| inRange | input | 2 | Input band code (00 reserved) |
| outRange | input | 2 | Output band code (00 reserved) |
| spreadEnN | input | 1 | Spread enable, active low |
| stop | input | 1 | Stops both clock outputs when high |
| freqOffset | output | 16 | Signed offset in units of 1/100000 of nominal |
| factorLog2 | output | 3 | Signed log2 of the multiplication factor |
| rangeErr | output | 1 | Reserved band code seen |
| spreadClkEn | output | 1 | Enable for the swept clock output |
| refClkEn | output | 1 | Enable for the unswept reference copy |

## Verification
The sweep is run through all eight width codes, each held for more than one period and changed mid-period. The full down and center triangles, their peak values and the late, phase-0 hand-over of settings are therefore compared every clock against a behavioural model. Toggling `spreadEnN` mid-sweep separates a correct return to zero at the period start from an immediate jump. All sixteen band code pairs separate the factor arithmetic from the reserved-code handling. Pulses on `stop` while spread is active show that only `stop` gates the two enables.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2
  } spread_mode_e;

  // Strobes from the sweep control to the offset datapath
  typedef struct packed {
    logic         atStart;   // phase is 0 this cycle
    spread_mode_e mode;      // applied spread style
    logic [1:0]   widthExp;  // applied width exponent
  } ssc_strobe_t;

  localparam int DOWN_BASE   = 1250;  // 1.25 % in 1e-5 units
  localparam int CENTER_BASE = 625;   // 0.625 % in 1e-5 units
  localparam int OFFSET_W    = 16;
endpackage

// File: rtl/ssc_range_decode.sv
module ssc_range_decode (
  input  logic [1:0]        inRange,
  input  logic [1:0]        outRange,
  output logic signed [2:0] factorLog2,
  output logic              rangeErr
);
  always_comb begin
    rangeErr = (inRange == 2'b00) || (outRange == 2'b00);
    if (rangeErr)
      factorLog2 = 3'sd0;
    else
      factorLog2 = 3'($signed({1'b0, outRange}) - $signed({1'b0, inRange}));
  end
endmodule

// File: rtl/ssc_sweep_ctrl.sv
module ssc_sweep_ctrl
  import ssc_pkg::*;
#(
  parameter int SWEEP_QUARTER_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  widthCode,
  input  logic        spreadEnN,
  input  logic        rangeErr,
  output ssc_strobe_t strb,
  output logic [SWEEP_QUARTER_LOG2+1:0] phase
);
  localparam int PHW = SWEEP_QUARTER_LOG2 + 2;

  spread_mode_e modeQ, modeReq;
  logic [1:0]   expQ;
  logic         atStart;

  assign atStart = (phase == '0);

  always_comb begin
    if (spreadEnN || rangeErr) modeReq = MODE_OFF;
    else if (widthCode[0])     modeReq = MODE_CENTER;
    else                       modeReq = MODE_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      modeQ <= MODE_OFF;
      expQ  <= 2'b00;
    end else begin
      phase <= phase + PHW'(1);
      if (atStart) begin
        modeQ <= modeReq;
        expQ  <= widthCode[2:1];
      end
    end
  end

  assign strb = '{atStart: atStart, mode: modeQ, widthExp: expQ};

  // R4: the applied setting only moves at phase 0
  a_r4_hold_config: assert property (@(posedge clk) disable iff (rst)
    !atStart |=> ($stable(modeQ) && $stable(expQ)));

  // R10: the phase wraps to 0 after its last value
  a_r10_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (&phase) |=> (phase == '0));
endmodule

// File: rtl/ssc_offset_path.sv
module ssc_offset_path
  import ssc_pkg::*;
#(
  parameter int SWEEP_QUARTER_LOG2 = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ssc_strobe_t                strb,
  input  logic [SWEEP_QUARTER_LOG2+1:0] phase,
  input  logic signed [2:0]          factorIn,
  input  logic                       errIn,
  input  logic                       stop,
  output logic signed [OFFSET_W-1:0] freqOffset,
  output logic signed [2:0]          factorLog2,
  output logic                       rangeErr,
  output logic                       spreadClkEn,
  output logic                       refClkEn
);
  localparam int Q    = 1 << SWEEP_QUARTER_LOG2;
  localparam int HALF = 2 * Q;
  localparam int FULL = 4 * Q;
  localparam int SHR  = SWEEP_QUARTER_LOG2 + 1;

  int   phI, triI, baseI, magI, offNextI;
  logic negFlag;

  always_comb begin
    phI     = int'(phase);
    triI    = 0;
    baseI   = 0;
    negFlag = 1'b0;
    case (strb.mode)
      MODE_DOWN: begin
        baseI   = DOWN_BASE << strb.widthExp;
        triI    = (phI <= HALF) ? phI : (FULL - phI);
        negFlag = 1'b1;
      end
      MODE_CENTER: begin
        baseI = CENTER_BASE << strb.widthExp;
        if (phI <= Q)          triI = 2 * phI;
        else if (phI <= HALF)  triI = 2 * (HALF - phI);
        else if (phI <= 3 * Q) triI = 2 * (phI - HALF);
        else                   triI = 2 * (FULL - phI);
        negFlag = (phI > HALF);
      end
      default: ;
    endcase
    magI     = (baseI * triI) >>> SHR;
    offNextI = negFlag ? -magI : magI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freqOffset  <= '0;
      factorLog2  <= 3'sd0;
      rangeErr    <= 1'b0;
      spreadClkEn <= 1'b0;
      refClkEn    <= 1'b0;
    end else begin
      freqOffset  <= OFFSET_W'(offNextI);
      factorLog2  <= factorIn;
      rangeErr    <= errIn;
      spreadClkEn <= !stop;
      refClkEn    <= !stop;
    end
  end

  // R1: down spread never raises the frequency
  a_r1_down_nonpos: assert property (@(posedge clk) disable iff (rst)
    (strb.mode == MODE_DOWN) |=> (freqOffset <= 0));

  // R2: center spread stays inside its half-width
  a_r2_center_bound: assert property (@(posedge clk) disable iff (rst)
    (strb.mode == MODE_CENTER) |->
      ((offNextI <= (CENTER_BASE << strb.widthExp)) &&
       (offNextI >= -(CENTER_BASE << strb.widthExp))));

  // R3: spread off holds the offset at zero
  a_r3_off_zero: assert property (@(posedge clk) disable iff (rst)
    (strb.mode == MODE_OFF) |=> (freqOffset == 0));

  // R10: phase 0 always yields zero offset
  a_r10_start_zero: assert property (@(posedge clk) disable iff (rst)
    strb.atStart |=> (freqOffset == 0));

  // R5: stop gates both clock enables
  a_r5_stop_gates: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!spreadClkEn && !refClkEn));

  // R6: the reference enable tracks the swept enable
  a_r6_ref_match: assert property (@(posedge clk) disable iff (rst)
    refClkEn == spreadClkEn);

  // R8: an error flag always reports a unity factor
  a_r8_err_factor: assert property (@(posedge clk) disable iff (rst)
    rangeErr |-> (factorLog2 == 3'sd0));
endmodule

// File: rtl/ssc_freq_ctrl.sv
module ssc_freq_ctrl
  import ssc_pkg::*;
#(
  parameter int SWEEP_QUARTER_LOG2 = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 widthCode,
  input  logic [1:0]                 inRange,
  input  logic [1:0]                 outRange,
  input  logic                       spreadEnN,
  input  logic                       stop,
  output logic signed [OFFSET_W-1:0] freqOffset,
  output logic signed [2:0]          factorLog2,
  output logic                       rangeErr,
  output logic                       spreadClkEn,
  output logic                       refClkEn
);
  ssc_strobe_t              strb;
  logic [SWEEP_QUARTER_LOG2+1:0] phase;
  logic signed [2:0]        factorComb;
  logic                     errComb;

  ssc_range_decode range_i (
    .inRange    (inRange),
    .outRange   (outRange),
    .factorLog2 (factorComb),
    .rangeErr   (errComb)
  );

  ssc_sweep_ctrl #(.SWEEP_QUARTER_LOG2(SWEEP_QUARTER_LOG2)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .widthCode (widthCode),
    .spreadEnN (spreadEnN),
    .rangeErr  (errComb),
    .strb      (strb),
    .phase     (phase)
  );

  ssc_offset_path #(.SWEEP_QUARTER_LOG2(SWEEP_QUARTER_LOG2)) path_i (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .phase       (phase),
    .factorIn    (factorComb),
    .errIn       (errComb),
    .stop        (stop),
    .freqOffset  (freqOffset),
    .factorLog2  (factorLog2),
    .rangeErr    (rangeErr),
    .spreadClkEn (spreadClkEn),
    .refClkEn    (refClkEn)
  );
endmodule

// File: tb/ssc_freq_ctrl_tb.sv
module ssc_freq_ctrl_tb_top;
  localparam int QL     = 4;
  localparam int QQ     = 1 << QL;
  localparam int PERIOD = 4 * QQ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] widthCode = 3'b000;
  logic [1:0] inRange = 2'b01, outRange = 2'b01;
  logic spreadEnN = 1'b0, stop = 1'b0;
  logic signed [15:0] freqOffset;
  logic signed [2:0]  factorLog2;
  logic rangeErr, spreadClkEn, refClkEn;

  int nChecks = 0, nFail = 0;
  logic checking = 1'b0;

  // model state
  int phaseM = 0, modeM = 0, expM = 0;
  int offE = 0, facE = 0, errE = 0, enE = 0;
  int offModeE = 0, offPhE = 0;
  bit pendE = 0;

  ssc_freq_ctrl #(.SWEEP_QUARTER_LOG2(QL)) dut_i (
    .clk(clk), .rst(rst), .widthCode(widthCode), .inRange(inRange),
    .outRange(outRange), .spreadEnN(spreadEnN), .stop(stop),
    .freqOffset(freqOffset), .factorLog2(factorLog2), .rangeErr(rangeErr),
    .spreadClkEn(spreadClkEn), .refClkEn(refClkEn)
  );

  always #10 clk = ~clk;

  function automatic int modelOffset(int ph, int md, int ex);
    int w, d, s;
    if (md == 1) begin
      w = 1250 << ex;
      d = (ph <= 2 * QQ) ? ph : PERIOD - ph;
      return -((w * d) / (2 * QQ));
    end else if (md == 2) begin
      w = 625 << ex;
      if (ph <= QQ)          s = ph;
      else if (ph <= 3 * QQ) s = 2 * QQ - ph;
      else                   s = ph - PERIOD;
      return (w * s) / QQ;
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    int reqMode, e;
    if (rst) begin
      phaseM = 0; modeM = 0; expM = 0;
      offE = 0; facE = 0; errE = 0; enE = 0; pendE = 0;
      offModeE = 0; offPhE = 0;
    end else begin
      e = (inRange == 0 || outRange == 0) ? 1 : 0;
      reqMode = (spreadEnN || e) ? 0 : (widthCode[0] ? 2 : 1);
      offE     = modelOffset(phaseM, modeM, expM);
      offModeE = modeM;
      offPhE   = phaseM;
      pendE    = (reqMode != modeM) || (reqMode != 0 && int'(widthCode[2:1]) != expM);
      errE     = e;
      facE     = e ? 0 : int'(outRange) - int'(inRange);
      enE      = stop ? 0 : 1;
      if (phaseM == 0) begin
        modeM = reqMode;
        expM  = int'(widthCode[2:1]);
      end
      phaseM = (phaseM + 1) % PERIOD;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (checking) begin
      string t;
      if (offPhE == 0)        t = "R10 offset at period start";
      else if (pendE)         t = "R4 offset holds old setting";
      else if (offModeE == 1) t = "R1 down offset";
      else if (offModeE == 2) t = "R2 center offset";
      else                    t = "R3 offset with spread off";
      chk(t, int'(freqOffset), offE);
      chk("R7 factorLog2", int'(factorLog2), facE);
      chk("R8 rangeErr", int'(rangeErr), errE);
      chk("R5 spreadClkEn", int'(spreadClkEn), enE);
      chk("R6 refClkEn", int'(refClkEn), enE);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 reset offset", int'(freqOffset), 0);
    chk("R9 reset factor", int'(factorLog2), 0);
    chk("R9 reset err", int'(rangeErr), 0);
    chk("R9 reset enables", int'(spreadClkEn) + int'(refClkEn), 0);
    rst = 1'b0;
    outRange = 2'b11;
    checking = 1'b1;
    cycles(2 * PERIOD);
    for (int c = 1; c < 8; c++) begin
      widthCode = 3'(c);
      cycles(PERIOD + PERIOD / 2 + 3);
    end
    widthCode = 3'b110;
    cycles(PERIOD + 5);
    spreadEnN = 1'b1;           // R3/R4: zero from next start
    cycles(PERIOD + 7);
    stop = 1'b1; cycles(5);     // R5/R6 while spread off
    spreadEnN = 1'b0;
    cycles(PERIOD + 9);
    stop = 1'b0; cycles(3);
    stop = 1'b1; cycles(2);
    stop = 1'b0; cycles(2);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        inRange = 2'(a); outRange = 2'(b);
        cycles(3);
      end
    inRange = 2'b10; outRange = 2'b00;  // R8: reserved code
    cycles(2 * PERIOD + 11);
    outRange = 2'b10;
    cycles(2 * PERIOD);
    rst = 1'b1; cycles(2);
    checking = 1'b0;
    chk("R9 reset offset mid-sweep", int'(freqOffset), 0);
    chk("R9 reset enables mid-sweep", int'(spreadClkEn) + int'(refClkEn), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule